// File: doc/BRIEF.md
# Glitch-Free Three-Source Clock Selector

This block produces the processor clock from one of three free-running inputs: an external reference clock, a PLL output and an on-chip ring oscillator. Two level inputs choose the source. The slow-select input forces the ring oscillator whenever it is set. When slow-select is clear, the PLL-select input chooses between the external clock and the PLL. All three sources run asynchronously to one another, so each source has its own enable stage. The stage is a two-flop synchronizer clocked on that source's falling edge. A source's stage may start to fill only when no other stage holds an enable. The hand-over is therefore break-before-make, and the output never carries a clipped pulse.

The block also drives two power controls. The first is a power-down request for the ring oscillator, asserted while the ring is neither wanted nor still gated through. The second is the PLL enable, which follows a software request. That enable is held on while the PLL is the chosen source or its stage is still active, so the PLL cannot be shut off under a live clock. A status output reports which source currently drives the output, and a flag reports that the chosen source is fully in place. The select inputs are expected to stay put until that flag rises.

Top module: `clk_src_sel`

## Requirements
- R1: While `rst_n` is low, `clk_out` stays low, `active_src` reads 3 (no source) and `src_ok` is low.
- R2: With `slow_sel` high, the output runs at the ring-oscillator frequency, and toggling `pll_sel` has no effect on it.
- R3: With `slow_sel` low, `pll_sel` high selects the PLL clock and `pll_sel` low selects the external clock. After the switch completes, `clk_out` has that source's period.
- R4: During a change of source, the old source's enable drops before the new one rises. At most one source is enabled at any time, so `active_src` reads 3 for a gap between the two.
- R5: Every high phase and every low phase of `clk_out` lasts at least half the period of the fastest source.
- R6: `ring_pd` is low while the ring oscillator is the chosen source or its enable stage is still active. Otherwise it is high.
- R7: `pll_en` is the OR of `pll_en_req`, "PLL is the chosen source" and "the PLL enable stage is active". Clearing `pll_en_req` while the PLL drives the output therefore leaves `pll_en` high until the switch to another source.
- R8: `active_src` encodes the enabled source as 0 = external, 1 = PLL, 2 = ring, 3 = none. `src_ok` is high exactly when the chosen source's stage is fully enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_ext | input | 1 | External reference clock |
| clk_pll | input | 1 | PLL output clock |
| clk_ring | input | 1 | Ring-oscillator clock |
| slow_sel | input | 1 | Forces the ring oscillator when high |
| pll_sel | input | 1 | Chooses the PLL (1) or the external clock (0) when slow_sel is low |
| pll_en_req | input | 1 | Software request to run the PLL |
| clk_out | output | 1 | Selected processor clock |
| ring_pd | output | 1 | Power-down request to the ring oscillator |
| pll_en | output | 1 | Guarded PLL enable |
| active_src | output | 2 | Source currently gated to the output |
| src_ok | output | 1 | Chosen source is fully in place |

## Verification
The hardest case to reach from the ports is the short dead interval between the old source's enable falling and the new one rising. Neither the enables nor the synchronizer flops are visible outside the block. The stimulus therefore switches between every pair of sources, including into and out of the slow ring oscillator. While the switch is in flight, the monitor polls `active_src` at a fine step to catch the "none" reading. A separate process times every phase of `clk_out` across the switches to expose any clipped pulse.

// File: rtl/clk_src_sel.sv
module clk_src_sel (
  input  logic       rst_n,
  input  logic       clk_ext,
  input  logic       clk_pll,
  input  logic       clk_ring,
  input  logic       slow_sel,
  input  logic       pll_sel,
  input  logic       pll_en_req,
  output logic       clk_out,
  output logic       ring_pd,
  output logic       pll_en,
  output logic [1:0] active_src,
  output logic       src_ok
);

  localparam int NSRC = 3;
  localparam logic [1:0] SRC_EXT  = 2'd0;
  localparam logic [1:0] SRC_PLL  = 2'd1;
  localparam logic [1:0] SRC_RING = 2'd2;
  localparam logic [1:0] SRC_NONE = 2'd3;

  logic [NSRC-1:0] clks;
  logic [NSRC-1:0] stg1;
  logic [NSRC-1:0] en;
  logic [1:0]      tgt;

  assign clks = {clk_ring, clk_pll, clk_ext};
  assign tgt  = slow_sel ? SRC_RING : (pll_sel ? SRC_PLL : SRC_EXT);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    localparam logic [NSRC-1:0] OTHERS = ~(NSRC'(1) << g);
    logic req, s1_q, s2_q;

    assign req = (tgt == 2'(g)) && ((en & OTHERS) == '0) && ((stg1 & OTHERS) == '0);

    always_ff @(negedge clks[g] or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= req;
        s2_q <= s1_q;
      end
    end

    assign stg1[g] = s1_q;
    assign en[g]   = s2_q;

    p_single_src_r4: assert property (@(posedge clks[g]) disable iff (!rst_n)
      $onehot0(en));

    p_break_make_r4: assert property (@(negedge clks[g]) disable iff (!rst_n)
      $rose(en[g]) |-> ((en & OTHERS) == '0));
  end

  assign clk_out = |(clks & en);
  assign ring_pd = !((tgt == SRC_RING) || stg1[2] || en[2]);
  assign pll_en  = pll_en_req || (tgt == SRC_PLL) || stg1[1] || en[1];

  always_comb begin
    if (en[0])      active_src = SRC_EXT;
    else if (en[1]) active_src = SRC_PLL;
    else if (en[2]) active_src = SRC_RING;
    else            active_src = SRC_NONE;
  end

  always_comb begin
    case (tgt)
      SRC_EXT:  src_ok = en[0];
      SRC_PLL:  src_ok = en[1];
      SRC_RING: src_ok = en[2];
      default:  src_ok = 1'b0;
    endcase
  end

  p_pll_alive_r7: assert property (@(posedge clk_pll) disable iff (!rst_n)
    (active_src == SRC_PLL) |-> pll_en);

  p_ring_alive_r6: assert property (@(posedge clk_ring) disable iff (!rst_n)
    (active_src == SRC_RING) |-> !ring_pd);

  always_comb begin
    if (rst_n === 1'b0) begin
      p_quiet_reset_r1: assert (clk_out == 1'b0 && active_src == SRC_NONE);
    end
  end

endmodule

// File: tb/clk_src_sel_tb.sv
`timescale 1ns/100ps
module clk_src_sel_tb;

  localparam real CLK_PERIOD  = 10.0;
  localparam real PLL_PERIOD  = 4.0;
  localparam real RING_PERIOD = 26.0;
  localparam real MIN_PHASE   = PLL_PERIOD / 2.0;

  logic rst_n = 1'b0;
  logic clk_ext = 1'b0, clk_pll = 1'b0, clk_ring = 1'b0;
  logic slow_sel = 1'b0, pll_sel = 1'b0, pll_en_req = 1'b0;
  logic clk_out, ring_pd, pll_en, src_ok;
  logic [1:0] active_src;

  int total = 0;
  int bad = 0;
  int served = 0;
  int q[$];

  always #(CLK_PERIOD/2.0)  clk_ext  = ~clk_ext;
  always #(PLL_PERIOD/2.0)  clk_pll  = ~clk_pll;
  always #(RING_PERIOD/2.0) clk_ring = ~clk_ring;

  clk_src_sel u_dut (
    .rst_n(rst_n), .clk_ext(clk_ext), .clk_pll(clk_pll), .clk_ring(clk_ring),
    .slow_sel(slow_sel), .pll_sel(pll_sel), .pll_en_req(pll_en_req),
    .clk_out(clk_out), .ring_pd(ring_pd), .pll_en(pll_en),
    .active_src(active_src), .src_ok(src_ok)
  );

  task automatic chk(input bit ok, input string req, input real act, input real exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0.2f expected=%0.2f at %0t", req, act, exp, $time);
    end
  endtask

  task automatic sel(input bit s, input bit p, input int e, input bit chg);
    int want;
    want = served + 1;
    slow_sel = s;
    pll_sel  = p;
    q.push_back(e + 4 * int'(chg));
    while (served < want) #1;
  endtask

  function automatic real src_period(input int e);
    if (e == 2) return RING_PERIOD;
    if (e == 1) return PLL_PERIOD;
    return CLK_PERIOD;
  endfunction

  // Scoreboard monitor
  initial begin
    #0.3;
    forever begin
      int item, e, n;
      bit chg, gap;
      real t0, t1, per;
      while (q.size() == 0) #1;
      item = q.pop_front();
      e = item % 4;
      chg = (item / 4) != 0;
      gap = 0;
      n = 0;
      while (!(src_ok && active_src == 2'(e)) && n < 400) begin
        if (active_src == 2'd3) gap = 1;
        #1;
        n++;
      end
      chk(src_ok && active_src == 2'(e), "R8", real'(active_src), real'(e));
      if (chg) chk(gap, "R4", real'(gap), 1.0);
      @(posedge clk_out) t0 = $realtime;
      @(posedge clk_out) t1 = $realtime;
      per = t1 - t0;
      if (e == 2) chk(per > src_period(e) - 0.05 && per < src_period(e) + 0.05, "R2", per, src_period(e));
      else        chk(per > src_period(e) - 0.05 && per < src_period(e) + 0.05, "R3", per, src_period(e));
      #0.3;
      served++;
    end
  end

  // Pulse-width monitor for R5
  real t_rise = 0.0, t_fall = 0.0;
  bit seen_rise = 0, seen_fall = 0;
  always @(posedge clk_out) begin
    if (seen_fall) chk($realtime - t_fall >= MIN_PHASE - 0.05, "R5", $realtime - t_fall, MIN_PHASE);
    t_rise = $realtime;
    seen_rise = 1;
  end
  always @(negedge clk_out) begin
    if (seen_rise) chk($realtime - t_rise >= MIN_PHASE - 0.05, "R5", $realtime - t_rise, MIN_PHASE);
    t_fall = $realtime;
    seen_fall = 1;
  end

  initial begin
    #400000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #0.5;
    #20;
    // R1 reset state
    chk(clk_out == 1'b0, "R1", real'(clk_out), 0.0);
    chk(active_src == 2'd3, "R1", real'(active_src), 3.0);
    chk(src_ok == 1'b0, "R1", real'(src_ok), 0.0);
    chk(ring_pd == 1'b1, "R6", real'(ring_pd), 1.0);
    chk(pll_en == 1'b0, "R7", real'(pll_en), 0.0);
    #10;
    rst_n = 1'b1;

    sel(0, 0, 0, 0);
    chk(ring_pd == 1'b1, "R6", real'(ring_pd), 1.0);

    pll_en_req = 1'b1;
    #1;
    chk(pll_en == 1'b1, "R7", real'(pll_en), 1.0);
    sel(0, 1, 1, 1);
    chk(ring_pd == 1'b1, "R6", real'(ring_pd), 1.0);

    sel(1, 1, 2, 1);
    chk(ring_pd == 1'b0, "R6", real'(ring_pd), 0.0);
    sel(1, 0, 2, 0);
    sel(1, 1, 2, 0);

    sel(0, 1, 1, 1);
    pll_en_req = 1'b0;
    #30;
    chk(pll_en == 1'b1, "R7", real'(pll_en), 1.0);
    chk(active_src == 2'd1, "R7", real'(active_src), 1.0);
    sel(0, 0, 0, 1);
    chk(pll_en == 1'b0, "R7", real'(pll_en), 0.0);

    sel(1, 0, 2, 1);
    chk(ring_pd == 1'b0, "R6", real'(ring_pd), 0.0);
    sel(0, 0, 0, 1);
    chk(ring_pd == 1'b1, "R6", real'(ring_pd), 1.0);

    pll_en_req = 1'b1;
    sel(0, 1, 1, 1);
    sel(0, 0, 0, 1);

    #50;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule